// File: doc/BRIEF.md
# LED Flasher and Status Pin Multiplexer

This block drives one dedicated LED pin and a bank of stop-status pins from a small set of configuration bits. It holds two mode registers and a stop register, loaded through a simple write strobe, and combines them with a busy flag, a "voice section active" level, an output sample magnitude and a flash-rate tick. The LEDs can be held on or made to blink. Two LEDs blink together or in opposite phase. Each LED can be gated by the section signal, and the first LED can follow the loudness of the audio.

Two of the stop pins are shared. Pin index 2 carries either the second LED or its own inverted stop bit. Pin index 0 carries either its own inverted stop bit or the busy flag. Every other stop pin shows the inverse of its stop register bit. All outputs are registered, so a change at the inputs shows up one clock later.

Top module: `led_status_mux`

## Requirements
- R1: While rst_n is low at a rising edge, led1_o and stop_pin_o go low. The stored mode bits and all stop bits reset to one and the flash phase resets to 0.
- R2: With wr_en high, wr_addr 0 loads the mode-A byte, 1 loads the mode-B byte and 2 loads the stop byte from wr_data. Address 3 changes nothing.
- R3: Each output at a rising edge is computed from the register contents, the flash phase and the input levels that were present just before that edge.
- R4: The flash phase inverts at every edge where flash_tick is high and holds otherwise.
- R5: Mode-A bit 7 = 1 makes the LED base drive follow the flash phase. With 0 the base drive is steady on.
- R6: Mode-B bit 5 = 1 gives LED2 the inverse of the flash phase (alternating). With 0 LED2 uses the same phase as LED1.
- R7: Mode-B bit 4 = 1 lights LED1 only while section_active is high.
- R8: Mode-B bit 3 = 1 gates LED2 with section_active. With 0 LED2 is gated by stop bit 2 (lit when the bit is 1).
- R9: Mode-B bit 2 = 0 lights LED1 only while sample_mag is strictly above VOL_THRESH (default 64). With 1 the magnitude has no effect.
- R10: Mode-A bit 6 = 1 puts LED2 on stop_pin_o[2]. With 0 that pin shows the inverse of stop bit 2.
- R11: Mode-A bit 2 = 1 puts the inverse of stop bit 0 on stop_pin_o[0]. With 0 that pin shows busy.
- R12: Every other stop_pin_o bit shows the inverse of its stop register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode-A, 1 mode-B, 2 stop |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Busy flag for the shared pin 0 |
| section_active | input | 1 | Voice section in progress |
| sample_mag | input | 8 | Current output sample magnitude |
| flash_tick | input | 1 | Flash-rate tick, one cycle wide |
| led1_o | output | 1 | LED1 drive, high = lit |
| stop_pin_o | output | 8 | Stop pins; index 0 and 2 are shared |

## Verification
Several functions can act in the same cycle. A register write can land on the same edge as a flash tick and as a change of busy or section_active, and the result must use the old register contents and the old phase for that edge. The random phase of the bench writes random bytes to random addresses, including the unused one, and toggles the tick and the live inputs on every cycle, so these collisions happen often. Every output is compared each cycle against a reference model that applies the edge semantics of R3. Directed sequences also hit the magnitude threshold exactly, and test each shared pin in both of its selections.

// File: rtl/led_mux_pkg.sv
// Package: shared bit positions, register addresses and the decoded
// configuration record for the LED flasher / status pin multiplexer.
package led_mux_pkg;

    // Bit positions inside the written mode bytes
    localparam int MA_FLASH    = 7;
    localparam int MA_PINC_LED = 6;
    localparam int MA_PINA_STP = 2;
    localparam int MB_ALT      = 5;
    localparam int MB_SEC1     = 4;
    localparam int MB_SEC2     = 3;
    localparam int MB_VOL_OFF  = 2;

    // Stop pin indices that are shared with other functions
    localparam int PIN_A = 0;
    localparam int PIN_C = 2;

    // Register addresses on the write port
    typedef enum logic [1:0] {
        ADDR_MODE_A = 2'd0,
        ADDR_MODE_B = 2'd1,
        ADDR_STOP   = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    // Decoded configuration bits held by the register block
    typedef struct packed {
        logic flash;       // blink instead of steady
        logic pin_c_led;   // shared pin C carries LED2
        logic pin_a_stop;  // shared pin A carries stop bit (else busy)
        logic alt;         // LED2 in opposite phase
        logic sec1;        // LED1 gated by section
        logic sec2;        // LED2 gated by section (else by stop C)
        logic vol_off;     // LED1 ignores sample magnitude
    } led_cfg_t;

    localparam led_cfg_t CFG_RESET = '1;

endpackage

// File: rtl/led_cfg_regs.sv
// Configuration register block. Holds the used mode bits and the full
// stop byte. Assumes a single write per cycle; reset loads all ones.
module led_cfg_regs
    import led_mux_pkg::*;
#(
    parameter int STOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [STOP_W-1:0] wr_data,
    output led_cfg_t          cfg,
    output logic [STOP_W-1:0] stop_bits
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    // Load the mode bits or stop byte addressed by the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= CFG_RESET;
            stop_bits <= '1;
        end else if (wr_en) begin
            case (addr)
                ADDR_MODE_A: begin
                    cfg.flash      <= wr_data[MA_FLASH];
                    cfg.pin_c_led  <= wr_data[MA_PINC_LED];
                    cfg.pin_a_stop <= wr_data[MA_PINA_STP];
                end
                ADDR_MODE_B: begin
                    cfg.alt     <= wr_data[MB_ALT];
                    cfg.sec1    <= wr_data[MB_SEC1];
                    cfg.sec2    <= wr_data[MB_SEC2];
                    cfg.vol_off <= wr_data[MB_VOL_OFF];
                end
                ADDR_STOP: stop_bits <= wr_data;
                default: ;
            endcase
        end
    end

    // R2: a mode-A write is visible on the next cycle
    p_wr_mode_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (cfg.flash == $past(wr_data[MA_FLASH])));

    // R2: a stop write is visible on the next cycle
    p_wr_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> (stop_bits == $past(wr_data)));

    // R2: address 3 leaves the stop byte unchanged
    p_wr_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> $stable(stop_bits));

endmodule

// File: rtl/led_flash_phase.sv
// Flash phase generator. Inverts a one-bit phase on every flash tick.
// Assumes the tick is a single-cycle pulse at the flash rate.
module led_flash_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_tick,
    output logic phase
);

    // Toggle phase on each tick, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= 1'b0;
        else if (flash_tick) phase <= ~phase;
    end

    // R4: tick inverts the phase
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_tick |=> (phase != $past(phase)));

    // R4: no tick, phase holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_tick |=> $stable(phase));

endmodule

// File: rtl/led_pattern.sv
// LED pattern logic (combinational). Forms the LED1 and LED2 on-states
// from the flash mode, phase option, section gates and volume follow.
module led_pattern
    import led_mux_pkg::*;
#(
    parameter int STOP_W     = 8,
    parameter int MAG_W      = 8,
    parameter int VOL_THRESH = 64
) (
    input  led_cfg_t          cfg,
    input  logic              phase,
    input  logic              section_active,
    input  logic              stop_c,
    input  logic [MAG_W-1:0]  sample_mag,
    output logic              led1_on,
    output logic              led2_on
);

    localparam logic [MAG_W-1:0] THR = MAG_W'(VOL_THRESH);

    logic base1, base2, gate1_sec, gate1_vol, gate2;

    // Base drive: steady on, or phase (inverted for LED2 when alternating)
    always_comb begin
        base1 = cfg.flash ? phase : 1'b1;
        base2 = cfg.flash ? (cfg.alt ? ~phase : phase) : 1'b1;
    end

    // Gating terms: section for LED1, section or stop C for LED2, loudness
    always_comb begin
        gate1_sec = cfg.sec1 ? section_active : 1'b1;
        gate1_vol = cfg.vol_off ? 1'b1 : (sample_mag > THR);
        gate2     = cfg.sec2 ? section_active : stop_c;
    end

    // Combine base drive with gates
    always_comb begin
        led1_on = base1 & gate1_sec & gate1_vol;
        led2_on = base2 & gate2;
    end

endmodule

// File: rtl/led_pin_mux.sv
// Output stage. Registers LED1 and all stop pins; stop pins show the
// inverse of their stop bits except where a shared pin is redirected.
// Assumes STOP_W is larger than both shared pin indices.
module led_pin_mux
    import led_mux_pkg::*;
#(
    parameter int STOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  led_cfg_t          cfg,
    input  logic [STOP_W-1:0] stop_bits,
    input  logic              busy,
    input  logic              led1_on,
    input  logic              led2_on,
    output logic              led1_o,
    output logic [STOP_W-1:0] stop_pin_o
);

    logic [STOP_W-1:0] pin_d;

    // Per-pin source selection
    for (genvar i = 0; i < STOP_W; i++) begin : g_pin
        if (i == PIN_A) begin : g_shared_a
            assign pin_d[i] = cfg.pin_a_stop ? ~stop_bits[i] : busy;
        end else if (i == PIN_C) begin : g_shared_c
            assign pin_d[i] = cfg.pin_c_led ? led2_on : ~stop_bits[i];
        end else begin : g_plain
            assign pin_d[i] = ~stop_bits[i];
        end
    end

    // Register the pin values, all low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led1_o     <= 1'b0;
            stop_pin_o <= '0;
        end else begin
            led1_o     <= led1_on;
            stop_pin_o <= pin_d;
        end
    end

    // R11: busy routed to pin A when selected
    p_busy_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.pin_a_stop |=> (stop_pin_o[PIN_A] == $past(busy)));

    // R12: a plain stop pin is the inverse of its bit
    p_plain_inv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stop_pin_o[1] != $past(stop_bits[1])));

    // R10: stop C shown inverted when LED2 is not on the shared pin
    p_pin_c_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.pin_c_led |=> (stop_pin_o[PIN_C] != $past(stop_bits[PIN_C])));

endmodule

// File: rtl/led_status_mux.sv
// Top: LED flasher and status pin multiplexer. Ties the register block,
// the phase generator, the pattern logic and the registered pin stage.
// Assumes flash_tick is synchronous to clk and one cycle wide.
module led_status_mux
    import led_mux_pkg::*;
#(
    parameter int STOP_W     = 8,
    parameter int MAG_W      = 8,
    parameter int VOL_THRESH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [STOP_W-1:0] wr_data,
    input  logic              busy,
    input  logic              section_active,
    input  logic [MAG_W-1:0]  sample_mag,
    input  logic              flash_tick,
    output logic              led1_o,
    output logic [STOP_W-1:0] stop_pin_o
);

    led_cfg_t          cfg;
    logic [STOP_W-1:0] stop_bits;
    logic              phase;
    logic              led1_on, led2_on;

    led_cfg_regs #(.STOP_W(STOP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .stop_bits (stop_bits)
    );

    led_flash_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .flash_tick (flash_tick),
        .phase      (phase)
    );

    led_pattern #(
        .STOP_W     (STOP_W),
        .MAG_W      (MAG_W),
        .VOL_THRESH (VOL_THRESH)
    ) u_pattern (
        .cfg            (cfg),
        .phase          (phase),
        .section_active (section_active),
        .stop_c         (stop_bits[PIN_C]),
        .sample_mag     (sample_mag),
        .led1_on        (led1_on),
        .led2_on        (led2_on)
    );

    led_pin_mux #(.STOP_W(STOP_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .stop_bits  (stop_bits),
        .busy       (busy),
        .led1_on    (led1_on),
        .led2_on    (led2_on),
        .led1_o     (led1_o),
        .stop_pin_o (stop_pin_o)
    );

    // R7: section gating keeps LED1 dark outside a section
    p_sec1_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sec1 && !section_active) |=> !led1_o);

    // R9: volume follow keeps LED1 dark at or below the threshold
    p_vol_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.vol_off && sample_mag <= MAG_W'(VOL_THRESH)) |=> !led1_o);

    // R5: flashing LED1 is dark in phase 0
    p_flash_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.flash && !phase) |=> !led1_o);

endmodule

// File: tb/led_status_mux_test.sv
module led_status_mux_test;

    localparam int THR = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       busy = 1'b0;
    logic       section_active = 1'b0;
    logic [7:0] sample_mag = '0;
    logic       flash_tick = 1'b0;
    logic       led1_o;
    logic [7:0] stop_pin_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_a = 8'hFF, m_b = 8'hFF, m_st = 8'hFF;
    logic       m_ph = 1'b0;
    logic [8:0] exp_out = '0;

    always #5 clk = ~clk;

    led_status_mux uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .section_active(section_active),
        .sample_mag(sample_mag), .flash_tick(flash_tick),
        .led1_o(led1_o), .stop_pin_o(stop_pin_o)
    );

    function automatic logic [8:0] model(input logic [7:0] a, b, st,
                                         input logic ph, bz, sec,
                                         input logic [7:0] mag);
        logic l1, l2;
        logic [7:0] p;
        l1 = (a[7] ? ph : 1'b1) & (b[4] ? sec : 1'b1) & (b[2] ? 1'b1 : (mag > THR));
        l2 = (a[7] ? (b[5] ? ~ph : ph) : 1'b1) & (b[3] ? sec : st[2]);
        p = ~st;
        p[2] = a[6] ? l2 : ~st[2];
        p[0] = a[2] ? ~st[0] : bz;
        return {l1, p};
    endfunction

    // one clock: predict output, advance model, sample after the edge
    task automatic step();
        if (!rst_n) begin
            exp_out = '0;
            m_a = 8'hFF; m_b = 8'hFF; m_st = 8'hFF; m_ph = 1'b0;
        end else begin
            exp_out = model(m_a, m_b, m_st, m_ph, busy, section_active, sample_mag);
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_a = wr_data;
                    2'd1: m_b = wr_data;
                    2'd2: m_st = wr_data;
                    default: ;
                endcase
            end
            if (flash_tick) m_ph = ~m_ph;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ad, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        logic a1, b1;
        @(negedge clk);
        // R1: reset state
        repeat (3) step();
        chk("R1 outputs in reset", {led1_o, stop_pin_o}, 9'h000);
        rst_n = 1'b1;
        step();
        chk("R1 after release, no section", {led1_o, stop_pin_o}, 9'h000);
        section_active = 1'b1;
        step();
        chk("R1 reset config: LED2 alternating on pin C", {led1_o, stop_pin_o}, 9'h004);
        // R4 / R6: tick flips phase
        flash_tick = 1'b1; step(); flash_tick = 1'b0;
        step();
        chk("R4 phase toggled, LED1 lit", {8'h0, led1_o}, 9'h1);
        chk("R6 alternating LED2 dark", {8'h0, stop_pin_o[2]}, 9'h0);
        // R12: stop byte inverted
        wr(2'd2, 8'h00);
        step();
        chk("R12 stop pins inverted", {led1_o, stop_pin_o}, {1'b1, 8'hFB});
        // R2: unused address ignored
        wr(2'd3, 8'h00);
        step();
        chk("R2 address 3 ignored", {led1_o, stop_pin_o}, {1'b1, 8'hFB});
        // R11: busy on pin A
        wr(2'd0, 8'h40);
        busy = 1'b1; step();
        chk("R11 busy high on pin A", {8'h0, stop_pin_o[0]}, 9'h1);
        busy = 1'b0; step();
        chk("R11 busy low on pin A", {8'h0, stop_pin_o[0]}, 9'h0);
        // R5: steady mode ignores phase
        flash_tick = 1'b1; step(); flash_tick = 1'b0;
        step();
        chk("R5 steady LED1 lit", {8'h0, led1_o}, 9'h1);
        flash_tick = 1'b1; step(); flash_tick = 1'b0;
        step();
        chk("R5 steady LED1 lit other phase", {8'h0, led1_o}, 9'h1);
        // R10: pin C source
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
        step();
        chk("R10 pin C shows inverted stop bit", {8'h0, stop_pin_o[2]}, 9'h0);
        wr(2'd0, 8'h40);
        step();
        chk("R10 pin C shows LED2", {8'h0, stop_pin_o[2]}, 9'h1);
        // R8: LED2 gated by stop C
        wr(2'd1, 8'hF7);
        step();
        chk("R8 stop C set lights LED2", {8'h0, stop_pin_o[2]}, 9'h1);
        wr(2'd2, 8'h00);
        step();
        chk("R8 stop C clear darkens LED2", {8'h0, stop_pin_o[2]}, 9'h0);
        // R7: LED1 section gate
        section_active = 1'b0;
        wr(2'd1, 8'hEF);
        step();
        chk("R7 gate off, LED1 lit", {8'h0, led1_o}, 9'h1);
        wr(2'd1, 8'hFF);
        step();
        chk("R7 gate on, no section, LED1 dark", {8'h0, led1_o}, 9'h0);
        // R9: volume threshold, strict compare
        wr(2'd1, 8'hEB);
        sample_mag = 8'(THR); step();
        chk("R9 magnitude at threshold", {8'h0, led1_o}, 9'h0);
        sample_mag = 8'(THR + 1); step();
        chk("R9 magnitude above threshold", {8'h0, led1_o}, 9'h1);
        // R5 / R6: synchronous flashing
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'hC4);
        wr(2'd2, 8'h04);
        step();
        a1 = led1_o;
        chk("R6 synchronous LED2 equals LED1", {8'h0, stop_pin_o[2]}, {8'h0, a1});
        flash_tick = 1'b1; step(); flash_tick = 1'b0;
        step();
        b1 = led1_o;
        chk("R5 flashing LED1 toggles", {8'h0, b1}, {8'h0, ~a1});
        // R3: random collisions against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            wr_en = ($urandom % 4) == 0;
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            busy = 1'($urandom);
            section_active = 1'($urandom);
            sample_mag = (($urandom % 3) == 0) ? 8'(THR) : 8'($urandom);
            flash_tick = 1'($urandom);
            rst_n = ($urandom % 300) != 0;
            step();
            chk("R3 output vs model", {led1_o, stop_pin_o}, exp_out);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule